// File: doc/BRIEF.md
# Video Frame Signature Checker

This block watches a parallel digital video stream and produces a 16-bit signature for each of the red, green and blue component buses. A pixel clock drives the block, and data-enable marks the active pixels. Vertical sync marks the frame boundaries. A run always covers a whole number of frames. It starts at a vertical-sync rising edge and ends at a later one, after a programmable number of frames. Only pixels with data-enable high go into the signatures.

When a run ends, the three signatures are copied to stable outputs and a done flag rises. Each new signature is compared with the result of the previous run. A source that sends the same picture over an error-free link must give the same signature every time. Any changed pixel value shows up as a per-channel mismatch flag. A saturating counter records how many runs had a mismatch. While enable stays high, the checker re-arms and starts the next run by itself, so long unattended tests need no software action.

Top module: `vid_sig_checker`

## Requirements
- R1: Each signature is a CRC-16 with generator polynomial 0x1021 (x^16+x^12+x^5+1). The register starts at 0xFFFF, takes one 8-bit component per clock with the most significant bit first, and has no output inversion. A single frame whose red components are the bytes 0x31..0x39 gives red signature 0x29B1.
- R2: The three channels are hashed independently. sig_r follows pix_r, sig_g follows pix_g and sig_b follows pix_b. Changing the value of one pixel on one channel changes only that channel's signature.
- R3: Only clocks with pix_de high inside a run update the signatures. Data presented while pix_de is low, or between runs, has no effect.
- R4: A run starts at the first pix_vs rising edge while run_en is high. The signature covers the frames that follow and carries across frame boundaries. The run ends at the N-th later rising edge, where N is frame_cnt as sampled at the start edge.
- R5: A frame_cnt of 0 is treated as 1.
- R6: sig_done is set one clock after the edge that ends a run. It clears when run_en is low or when the next run starts.
- R7: sig_mism bit 0 is red, bit 1 is green and bit 2 is blue. Each bit sets when its channel's new signature differs from that of the previous completed run, and it then stays set until reset. The first run after reset only records a reference and never sets a bit.
- R8: While run_en stays high, the next pix_vs rising edge after a completed run starts a new run without any other action.
- R9: bad_runs counts once for each completed run with at least one differing channel, and it holds at its maximum value.
- R10: After reset, all signatures, sig_done, sig_mism and bad_runs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Enables the checker and its automatic repeat |
| frame_cnt | input | CNT_W | Frames per run (0 means 1) |
| pix_de | input | 1 | Active-pixel qualifier |
| pix_vs | input | 1 | Vertical sync, rising edge marks a frame start |
| pix_r | input | PIX_W | Red component |
| pix_g | input | PIX_W | Green component |
| pix_b | input | PIX_W | Blue component |
| sig_r | output | 16 | Red signature of the last completed run |
| sig_g | output | 16 | Green signature of the last completed run |
| sig_b | output | 16 | Blue signature of the last completed run |
| sig_done | output | 1 | A run has completed |
| sig_mism | output | 3 | Sticky per-channel change flags {b,g,r} |
| bad_runs | output | ERR_W | Saturating count of runs with a change |

## Verification
Saturation of the run counter is the hardest state to reach from the ports. At the default width it would take tens of thousands of completed runs. The bench therefore builds the block with a 3-bit counter and uses tiny frames of two lines by four pixels. It then alternates corrupted and clean runs, so that every run differs from the one before it. The boundary at which one run ends and the next re-arms is reached with back-to-back runs under a constantly high enable. Junk is driven on the buses during blanking and in the gap frames to show that those clocks are ignored.

// File: rtl/vsc_pkg.sv
package vsc_pkg;

    localparam int              CRC_W    = 16;
    localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;
    localparam logic [CRC_W-1:0] CRC_SEED = 16'hFFFF;
    localparam int              NCH      = 3;

    typedef enum logic {
        ST_WAIT = 1'b0,
        ST_RUN  = 1'b1
    } vsc_state_e;

    // Per-run strobes shared by every lane
    typedef struct packed {
        logic clr;   // preset the lanes at a run start
        logic upd;   // hash the current component
        logic fin;   // run completes on this clock
    } lane_ctl_t;

endpackage

// File: rtl/vsc_crc_lane.sv
module vsc_crc_lane
    import vsc_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  lane_ctl_t        ctl,
    input  logic [PIX_W-1:0] din,
    output logic [CRC_W-1:0] crc_o
);

    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] nxt;

    // One whole component per clock, most significant bit enters first
    always_comb begin
        nxt = crc_q;
        for (int i = PIX_W - 1; i >= 0; i--) begin
            nxt = {nxt[CRC_W-2:0], 1'b0} ^ (CRC_POLY & {CRC_W{nxt[CRC_W-1] ^ din[i]}});
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          crc_q <= CRC_SEED;
        else if (ctl.clr) crc_q <= CRC_SEED;
        else if (ctl.upd) crc_q <= nxt;
    end

    assign crc_o = crc_q;

    // R3
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl.clr && !ctl.upd) |=> $stable(crc_q));

    // R1
    preset_on_start_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.clr |=> (crc_q == CRC_SEED));

endmodule

// File: rtl/vsc_frame_ctl.sv
module vsc_frame_ctl
    import vsc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    input  logic [CNT_W-1:0] frame_cnt,
    input  logic             pix_de,
    input  logic             pix_vs,
    output lane_ctl_t        ctl_o,
    output logic             done_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    vsc_state_e       state_q;
    logic             vs_q;
    logic [CNT_W-1:0] target_q;
    logic [CNT_W-1:0] seen_q;
    logic             done_q;

    logic             vs_rise;
    logic             last_frame;
    logic [CNT_W-1:0] target_d;

    assign vs_rise    = pix_vs && !vs_q;
    assign last_frame = (seen_q + ONE) == target_q;
    assign target_d   = (frame_cnt == '0) ? ONE : frame_cnt;

    always_comb begin
        ctl_o.clr = run_en && (state_q == ST_WAIT) && vs_rise;
        ctl_o.upd = run_en && (state_q == ST_RUN) && pix_de;
        ctl_o.fin = run_en && (state_q == ST_RUN) && vs_rise && last_frame;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_WAIT;
            vs_q     <= 1'b0;
            target_q <= ONE;
            seen_q   <= '0;
            done_q   <= 1'b0;
        end else begin
            vs_q <= pix_vs;
            if (!run_en) begin
                state_q <= ST_WAIT;
                seen_q  <= '0;
                done_q  <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_WAIT: begin
                        if (vs_rise) begin
                            state_q  <= ST_RUN;
                            target_q <= target_d;
                            seen_q   <= '0;
                            done_q   <= 1'b0;
                        end
                    end
                    ST_RUN: begin
                        if (vs_rise) begin
                            if (last_frame) begin
                                state_q <= ST_WAIT;
                                done_q  <= 1'b1;
                            end else begin
                                seen_q <= seen_q + ONE;
                            end
                        end
                    end
                    default: state_q <= ST_WAIT;
                endcase
            end
        end
    end

    assign done_o = done_q;

    // R6
    done_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> !done_q);

    // R4
    seen_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN) |-> (seen_q < target_q));

    // R5
    target_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        target_q != '0);

    // R8
    rearm_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_o.fin |=> (state_q == ST_WAIT) && done_q);

    // R6
    done_clear_on_start_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_o.clr |=> !done_q);

endmodule

// File: rtl/vsc_sig_hold.sv
module vsc_sig_hold
    import vsc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             fin,
    input  logic             ref_ok,
    input  logic [CRC_W-1:0] crc_in,
    output logic [CRC_W-1:0] sig_o,
    output logic             diff_o,
    output logic             mism_o
);

    logic [CRC_W-1:0] sig_q;
    logic             mism_q;

    // The held output doubles as the reference for the next run
    assign diff_o = (crc_in != sig_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            sig_q  <= '0;
            mism_q <= 1'b0;
        end else if (fin) begin
            sig_q <= crc_in;
            if (ref_ok && diff_o) mism_q <= 1'b1;
        end
    end

    assign sig_o  = sig_q;
    assign mism_o = mism_q;

    // R7
    mism_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        mism_q |=> mism_q);

    // R7
    first_run_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (fin && !ref_ok) |=> (mism_q == $past(mism_q)));

    // R4
    sig_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !fin |=> $stable(sig_q));

endmodule

// File: rtl/vid_sig_checker.sv
module vid_sig_checker
    import vsc_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int CNT_W = 8,
    parameter int ERR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    input  logic [CNT_W-1:0] frame_cnt,
    input  logic             pix_de,
    input  logic             pix_vs,
    input  logic [PIX_W-1:0] pix_r,
    input  logic [PIX_W-1:0] pix_g,
    input  logic [PIX_W-1:0] pix_b,
    output logic [CRC_W-1:0] sig_r,
    output logic [CRC_W-1:0] sig_g,
    output logic [CRC_W-1:0] sig_b,
    output logic             sig_done,
    output logic [NCH-1:0]   sig_mism,
    output logic [ERR_W-1:0] bad_runs
);

    localparam logic [ERR_W-1:0] ERR_MAX = {ERR_W{1'b1}};
    localparam logic [ERR_W-1:0] ERR_ONE = ERR_W'(1);

    lane_ctl_t        ctl;
    logic [PIX_W-1:0] chan_d   [NCH];
    logic [CRC_W-1:0] chan_crc [NCH];
    logic [CRC_W-1:0] chan_sig [NCH];
    logic [NCH-1:0]   chan_diff;
    logic             ref_ok_q;
    logic [ERR_W-1:0] bad_q;
    logic             any_change;

    always_comb begin
        chan_d[0] = pix_r;
        chan_d[1] = pix_g;
        chan_d[2] = pix_b;
    end

    vsc_frame_ctl #(
        .CNT_W (CNT_W)
    ) u_ctl (
        .clk       (clk),
        .rst       (rst),
        .run_en    (run_en),
        .frame_cnt (frame_cnt),
        .pix_de    (pix_de),
        .pix_vs    (pix_vs),
        .ctl_o     (ctl),
        .done_o    (sig_done)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        vsc_crc_lane #(
            .PIX_W (PIX_W)
        ) u_lane (
            .clk   (clk),
            .rst   (rst),
            .ctl   (ctl),
            .din   (chan_d[ch]),
            .crc_o (chan_crc[ch])
        );

        vsc_sig_hold u_hold (
            .clk    (clk),
            .rst    (rst),
            .fin    (ctl.fin),
            .ref_ok (ref_ok_q),
            .crc_in (chan_crc[ch]),
            .sig_o  (chan_sig[ch]),
            .diff_o (chan_diff[ch]),
            .mism_o (sig_mism[ch])
        );
    end

    assign any_change = ref_ok_q && (|chan_diff);

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_ok_q <= 1'b0;
            bad_q    <= '0;
        end else if (ctl.fin) begin
            ref_ok_q <= 1'b1;
            if (any_change && bad_q != ERR_MAX) bad_q <= bad_q + ERR_ONE;
        end
    end

    assign sig_r    = chan_sig[0];
    assign sig_g    = chan_sig[1];
    assign sig_b    = chan_sig[2];
    assign bad_runs = bad_q;

    // R9
    bad_step_chk: assert property (@(posedge clk) disable iff (rst)
        (bad_q == $past(bad_q)) || (bad_q == $past(bad_q) + ERR_ONE));

    // R9
    bad_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (bad_q == ERR_MAX) |=> (bad_q == ERR_MAX));

    // R7
    no_count_before_ref_chk: assert property (@(posedge clk) disable iff (rst)
        !ref_ok_q |=> (bad_q == '0));

endmodule

// File: tb/vid_sig_checker_bench.sv
module vid_sig_checker_bench;

    localparam int TB_ERR_W = 3;
    localparam int LINES    = 2;
    localparam int PPL      = 4;

    // vector: {frames programmed[7:0], corrupt channel[3:0] (3 = none), corrupt pixel[3:0]}
    localparam int NVEC = 7;
    localparam logic [15:0] VEC [NVEC] = '{
        {8'd2, 4'd3, 4'd0},
        {8'd2, 4'd3, 4'd0},
        {8'd2, 4'd1, 4'd5},
        {8'd2, 4'd3, 4'd0},
        {8'd1, 4'd0, 4'd2},
        {8'd0, 4'd3, 4'd0},
        {8'd1, 4'd3, 4'd0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run_en = 1'b0;
    logic [7:0]  frame_cnt = 8'd1;
    logic        pix_de = 1'b0;
    logic        pix_vs = 1'b0;
    logic [7:0]  pix_r = 8'd0, pix_g = 8'd0, pix_b = 8'd0;
    logic [15:0] sig_r, sig_g, sig_b;
    logic        sig_done;
    logic [2:0]  sig_mism;
    logic [TB_ERR_W-1:0] bad_runs;

    int n_chk = 0;
    int n_bad = 0;

    logic [15:0] exp_sig  [3];
    logic [15:0] prev_sig [3];
    logic        have_ref = 1'b0;
    logic [2:0]  exp_mism = 3'b000;
    int          exp_bad  = 0;

    always #4 clk = ~clk;

    vid_sig_checker #(.PIX_W(8), .CNT_W(8), .ERR_W(TB_ERR_W)) u_vid_sig_checker (
        .clk(clk), .rst(rst), .run_en(run_en), .frame_cnt(frame_cnt),
        .pix_de(pix_de), .pix_vs(pix_vs), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
        .sig_r(sig_r), .sig_g(sig_g), .sig_b(sig_b), .sig_done(sig_done),
        .sig_mism(sig_mism), .bad_runs(bad_runs)
    );

    function automatic logic [15:0] m_crc(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c ^ {d, 8'h00};
        for (int k = 0; k < 8; k++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
        return r;
    endfunction

    function automatic logic [7:0] pix_val(input int ch, input int l, input int p);
        return 8'((l * 37 + p * 11 + ch * 90 + 7) & 255);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic vs_pulse();
        pix_de = 1'b0; pix_vs = 1'b1;
        repeat (2) step();
        pix_vs = 1'b0;
        repeat (2) step();
    endtask

    // frame: sync, then lines of active pixels with junk on the buses while blanked
    task automatic send_frame(input int cch, input int cpx, input bit corrupt, input int salt);
        vs_pulse();
        for (int l = 0; l < LINES; l++) begin
            for (int p = 0; p < PPL; p++) begin
                pix_de = 1'b1;
                pix_r = pix_val(0, l, p) ^ ((corrupt && cch == 0 && l * PPL + p == cpx) ? 8'h01 : 8'h00);
                pix_g = pix_val(1, l, p) ^ ((corrupt && cch == 1 && l * PPL + p == cpx) ? 8'h01 : 8'h00);
                pix_b = pix_val(2, l, p) ^ ((corrupt && cch == 2 && l * PPL + p == cpx) ? 8'h01 : 8'h00);
                step();
            end
            pix_de = 1'b0;
            pix_r = 8'(salt * 13 + l); pix_g = 8'(salt * 7 + 3); pix_b = 8'(salt + 99);
            repeat (2) step();
        end
    endtask

    task automatic model_run(input int nfr, input int cch, input int cpx);
        for (int ch = 0; ch < 3; ch++) begin
            exp_sig[ch] = 16'hFFFF;
            for (int f = 0; f < nfr; f++)
                for (int i = 0; i < LINES * PPL; i++)
                    exp_sig[ch] = m_crc(exp_sig[ch],
                        pix_val(ch, i / PPL, i % PPL) ^ ((f == 0 && ch == cch && i == cpx) ? 8'h01 : 8'h00));
        end
    endtask

    task automatic model_finish();
        logic any;
        any = 1'b0;
        for (int ch = 0; ch < 3; ch++) begin
            if (have_ref && exp_sig[ch] != prev_sig[ch]) begin
                exp_mism[ch] = 1'b1;
                any = 1'b1;
            end
            prev_sig[ch] = exp_sig[ch];
        end
        if (any && exp_bad < (1 << TB_ERR_W) - 1) exp_bad++;
        have_ref = 1'b1;
    endtask

    task automatic check_outputs(input string tag);
        chk({tag, " R2 sig_r"}, {16'h0, sig_r}, {16'h0, exp_sig[0]});
        chk({tag, " R2 sig_g"}, {16'h0, sig_g}, {16'h0, exp_sig[1]});
        chk({tag, " R2 sig_b"}, {16'h0, sig_b}, {16'h0, exp_sig[2]});
        chk({tag, " R6 done"},  {31'h0, sig_done}, 32'd1);
        chk({tag, " R7 mism"},  {29'h0, sig_mism}, {29'h0, exp_mism});
        chk({tag, " R9 bad_runs"}, 32'(bad_runs), 32'(exp_bad));
    endtask

    // one complete run: programmed count, frames, closing edge, then checks
    task automatic do_run(input int nprog, input int cch, input int cpx, input int salt, input string tag);
        int nfr;
        nfr = (nprog == 0) ? 1 : nprog;
        frame_cnt = 8'(nprog);
        for (int f = 0; f < nfr; f++) begin
            send_frame(cch, cpx, (f == 0 && cch < 3), salt + f);
            // R6: the start edge of a run clears done
            if (f == 0) chk({tag, " R6 done cleared at start"}, {31'h0, sig_done}, 32'd0);
        end
        vs_pulse();   // closing edge (R4), gap frame follows in wait state (R8)
        pix_r = 8'hA5; pix_g = 8'h5A; pix_b = 8'h3C; pix_de = 1'b1;   // R3: gap data ignored
        repeat (2) step();
        pix_de = 1'b0;
        model_run(nfr, cch, cpx);
        model_finish();
        check_outputs(tag);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) step();
        rst = 1'b0;
        step();
        // R10 reset state
        chk("R10 sig_r", {16'h0, sig_r}, 32'd0);
        chk("R10 sig_g", {16'h0, sig_g}, 32'd0);
        chk("R10 sig_b", {16'h0, sig_b}, 32'd0);
        chk("R10 done", {31'h0, sig_done}, 32'd0);
        chk("R10 mism", {29'h0, sig_mism}, 32'd0);
        chk("R10 bad_runs", 32'(bad_runs), 32'd0);

        // R4/R8: enable once, then runs follow back to back
        run_en = 1'b1;
        step();
        for (int v = 0; v < NVEC; v++) begin
            do_run(int'(VEC[v][15:8]), int'(VEC[v][7:4]), int'(VEC[v][3:0]), v * 5,
                   $sformatf("vec%0d R4 R5", v));
        end

        // R6: dropping enable clears done
        run_en = 1'b0;
        repeat (2) step();
        chk("R6 done after disable", {31'h0, sig_done}, 32'd0);

        // R9: alternate runs until the narrowed counter saturates
        run_en = 1'b1;
        step();
        for (int k = 0; k < 10; k++) begin
            do_run(1, (k % 2 == 0) ? 2 : 3, 1, 40 + k, $sformatf("sat%0d R9", k));
        end
        chk("R9 saturated", 32'(bad_runs), 32'((1 << TB_ERR_W) - 1));

        // R1 known answer after a fresh reset; R7 first run sets no flag
        run_en = 1'b0;
        rst = 1'b1;
        repeat (2) step();
        rst = 1'b0;
        run_en = 1'b1;
        frame_cnt = 8'd1;
        step();
        vs_pulse();
        for (int i = 0; i < 9; i++) begin
            pix_de = 1'b1; pix_r = 8'h31 + 8'(i); pix_g = 8'h00; pix_b = 8'hFF;
            step();
        end
        pix_de = 1'b0;
        repeat (2) step();
        vs_pulse();
        exp_sig[1] = 16'hFFFF;
        exp_sig[2] = 16'hFFFF;
        for (int i = 0; i < 9; i++) begin
            exp_sig[1] = m_crc(exp_sig[1], 8'h00);
            exp_sig[2] = m_crc(exp_sig[2], 8'hFF);
        end
        chk("R1 known answer red", {16'h0, sig_r}, 32'h29B1);
        chk("R2 green zeros", {16'h0, sig_g}, {16'h0, exp_sig[1]});
        chk("R2 blue ones", {16'h0, sig_b}, {16'h0, exp_sig[2]});
        chk("R7 first run no mismatch", {29'h0, sig_mism}, 32'd0);
        chk("R9 first run no count", 32'(bad_runs), 32'd0);
        chk("R6 done after known answer", {31'h0, sig_done}, 32'd1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule